// File: doc/BRIEF.md
# Serial Transmit Queue with Fill-Level Request

This block buffers outgoing words between a host write port and the shift register of a synchronous serial transmitter. The host presents one word at a time on a write strobe. The block either hands the word straight to an idle shift register or holds it in an eight-entry first-in first-out store. Each time the shift register becomes free, the block passes it the oldest held word.

The host sees three things. The first is the number of words currently held. The second is a transmit request, which is raised whenever that number is at or below a programmable threshold so that software knows it can refill. The third is a sticky error flag, which is set when a word arrives with no room for it. In that case the newest held word is replaced rather than the new word being lost. An optional one-cycle error interrupt pulse accompanies the flag. A flush pulse discards every held word without disturbing a transfer already under way.

With the queue switched off, the block behaves as a plain single-word holding buffer. The word width is configurable from 2 to 16 bits, and bits above the configured width are cleared before a word is stored or sent.

Top module: `sertx_queue`

## Requirements
- R1: With `fifo_en`=1 the queue holds up to 8 words, and words reach `sh_data` (one `sh_load` pulse each) in the order they were written.
- R2: Each written word is masked to an effective width of `len_cfg`+1 bits, with a minimum of 2 (`len_cfg` 0 and 1 both give 2 bits, and 15 gives 16 bits). Bits at or above that width are zero on `sh_data`.
- R3: `fill_lvl` equals the number of words held in the queue, from 0 to 8. A word handed directly to the shift register is not counted.
- R4: `tx_req` is 1 exactly when `fill_lvl` <= `thresh` (unsigned, 4 bits), so `thresh` values from 8 to 15 keep it at 1.
- R5: A write accepted while the queue is empty, `sh_busy` is 0 and no load is pending produces `sh_load`=1 with that word in the next cycle, and `fill_lvl` stays 0.
- R6: A write while the queue is full and nothing is leaving it overwrites the newest held word, leaves `fill_lvl` unchanged and sets `tx_err`. When `err_en`=1, `err_irq` pulses for exactly one cycle, in the cycle after the write. When `err_en`=0 it stays 0.
- R7: A `flush` pulse makes `fill_lvl` 0 in the next cycle and discards all held words. A write in the same cycle is ignored, no load is issued for that cycle, and a transfer in progress continues.
- R8: When `sh_busy` is 0, no load was issued in the previous cycle and the queue is not empty, the oldest word is loaded and `fill_lvl` drops by one. `sh_load` is never asserted in the cycle after `sh_busy` was 1.
- R9: With `fifo_en`=0 the capacity is one word. A second write while that word is held and the shift register is busy is an overflow, as in R6.
- R10: `tx_err` stays set until an `err_clr` pulse. An overflow in the same cycle as `err_clr` leaves it set.
- R11: After reset `fill_lvl`=0, `tx_req`=1, `tx_err`=0, `err_irq`=0 and `sh_load`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: eight-word queue, 0: single-word buffer |
| len_cfg | input | 4 | Word width minus one (minimum width 2) |
| thresh | input | 4 | Fill level at or below which `tx_req` is raised |
| err_en | input | 1 | Enables the `err_irq` pulse on overflow |
| flush | input | 1 | One-cycle pulse that discards all held words |
| err_clr | input | 1 | One-cycle pulse that clears `tx_err` |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word |
| sh_busy | input | 1 | Shift register is transferring a word |
| sh_load | output | 1 | One-cycle pulse: `sh_data` is to be loaded |
| sh_data | output | 16 | Word for the shift register |
| fill_lvl | output | 4 | Number of words held |
| tx_req | output | 1 | Transmit request (fill level at or below threshold) |
| tx_err | output | 1 | Sticky overflow flag |
| err_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench first writes one word into an idle, empty block. This shows the direct hand-off apart from the queued path, because the load appears with the fill level still zero. It then holds the shift register busy and writes a burst to full, followed by one extra word. This separates the ordinary push from the overwrite of the newest entry, and the scoreboard sees the replaced word come out last in place of the dropped one. Varying `len_cfg` on both the direct and the queued path shows the masking applies on each. A flush together with a write, a disabled-queue burst and an overflow landing on an error clear show flush priority, the one-word capacity and set-over-clear priority apart from the normal paths.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Decision taken for a host write in a given cycle
  typedef enum logic [1:0] {
    WA_NONE      = 2'd0,
    WA_BYPASS    = 2'd1,
    WA_PUSH      = 2'd2,
    WA_OVERWRITE = 2'd3
  } wr_act_e;

endpackage

// File: rtl/sertx_fmt.sv
// Clears every bit at or above the configured word width.
module sertx_fmt #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int MIN_W  = 2
) (
  input  logic [LEN_W-1:0]  len_cfg,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] fmt
);

  localparam int WC_W = LEN_W + 1;

  logic [WC_W-1:0] eff_w;

  always_comb begin
    eff_w = WC_W'(len_cfg) + WC_W'(1);
    if (eff_w < WC_W'(MIN_W)) begin
      eff_w = WC_W'(MIN_W);
    end
  end

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam logic [WC_W-1:0] BIT_IDX = WC_W'(b);
      assign fmt[b] = raw[b] & (BIT_IDX < eff_w);
    end
  endgenerate

endmodule

// File: rtl/sertx_store.sv
// Word storage: one register per entry, a single write port and a combinational read port.
module sertx_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic              ent_we;
      logic [DATA_W-1:0] ent_q;

      assign ent_we = wr_en && (wr_addr == PTR_W'(e));

      always_ff @(posedge clk) begin
        if (ent_we) begin
          ent_q <= wr_data;
        end
      end

      assign slot[e] = ent_q;
    end
  endgenerate

  assign rd_data = slot[rd_addr];

endmodule

// File: rtl/sertx_ctl.sv
// Pointer, count and load sequencing for the transmit queue.
module sertx_ctl
  import sertx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             flush,
  input  logic             wr_req,
  input  logic             sh_busy,
  output wr_act_e          act,
  output logic             pop,
  output logic             ld_nxt,
  output logic             ld_q,
  output logic             st_we,
  output logic [PTR_W-1:0] st_waddr,
  output logic [PTR_W-1:0] st_raddr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cap;
  logic [PTR_W-1:0] wptr_q, wptr_nxt, rptr_q, rptr_nxt;
  logic             sh_idle, wr_ok, is_full, push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    if (p == '0) return PTR_W'(DEPTH - 1);
    return p - PTR_W'(1);
  endfunction

  // Write decision and load request
  always_comb begin
    sh_idle = !sh_busy && !ld_q;
    wr_ok   = wr_req && !flush;
    cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    is_full = (cnt_q >= cap);
    pop     = !flush && sh_idle && (cnt_q != '0);

    if (!wr_ok) begin
      act = WA_NONE;
    end else if ((cnt_q == '0) && sh_idle) begin
      act = WA_BYPASS;
    end else if (is_full && !pop) begin
      act = WA_OVERWRITE;
    end else begin
      act = WA_PUSH;
    end

    push     = (act == WA_PUSH);
    ld_nxt   = pop || (act == WA_BYPASS);
    st_we    = push || (act == WA_OVERWRITE);
    st_waddr = (act == WA_OVERWRITE) ? ptr_dec(wptr_q) : wptr_q;
    st_raddr = rptr_q;
  end

  // Next state
  always_comb begin
    cnt_nxt  = cnt_q;
    wptr_nxt = wptr_q;
    rptr_nxt = rptr_q;
    if (flush) begin
      cnt_nxt  = '0;
      wptr_nxt = '0;
      rptr_nxt = '0;
    end else begin
      cnt_nxt = cnt_q + CNT_W'(push) - CNT_W'(pop);
      if (push) wptr_nxt = ptr_inc(wptr_q);
      if (pop)  rptr_nxt = ptr_inc(rptr_q);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      ld_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      wptr_q <= wptr_nxt;
      rptr_q <= rptr_nxt;
      ld_q   <= ld_nxt;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sertx_err.sv
// Sticky overflow flag and optional interrupt pulse.
module sertx_err (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic err_en,
  input  logic err_clr,
  output logic tx_err,
  output logic err_irq
);

  logic err_q, err_nxt, irq_q, irq_nxt;

  always_comb begin
    err_nxt = err_q;
    if (err_clr) err_nxt = 1'b0;
    if (ovf)     err_nxt = 1'b1;
    irq_nxt = ovf && err_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      err_q <= err_nxt;
      irq_q <= irq_nxt;
    end
  end

  assign tx_err  = err_q;
  assign err_irq = irq_q;

endmodule

// File: rtl/sertx_queue.sv
// Transmit word queue in front of a serial shift register.
module sertx_queue
  import sertx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int THR_W  = 4,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [LEN_W-1:0]  len_cfg,
  input  logic [THR_W-1:0]  thresh,
  input  logic              err_en,
  input  logic              flush,
  input  logic              err_clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sh_busy,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data,
  output logic [CNT_W-1:0]  fill_lvl,
  output logic              tx_req,
  output logic              tx_err,
  output logic              err_irq
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  wr_act_e           act;
  logic              pop, ld_nxt, ld_q, st_we;
  logic [PTR_W-1:0]  st_waddr, st_raddr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] fmt_data, rd_data, load_src, data_q;

  sertx_fmt #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_W(2)) u_fmt (
    .len_cfg (len_cfg),
    .raw     (wr_data),
    .fmt     (fmt_data)
  );

  sertx_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .flush    (flush),
    .wr_req   (wr_en),
    .sh_busy  (sh_busy),
    .act      (act),
    .pop      (pop),
    .ld_nxt   (ld_nxt),
    .ld_q     (ld_q),
    .st_we    (st_we),
    .st_waddr (st_waddr),
    .st_raddr (st_raddr),
    .cnt      (cnt)
  );

  sertx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .wr_en   (st_we),
    .wr_addr (st_waddr),
    .wr_data (fmt_data),
    .rd_addr (st_raddr),
    .rd_data (rd_data)
  );

  sertx_err u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf     (act == WA_OVERWRITE),
    .err_en  (err_en),
    .err_clr (err_clr),
    .tx_err  (tx_err),
    .err_irq (err_irq)
  );

  // Word handed to the shift register: oldest held entry, else the fresh write
  always_comb begin
    load_src = pop ? rd_data : fmt_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (ld_nxt) begin
      data_q <= load_src;
    end
  end

  assign sh_load  = ld_q;
  assign sh_data  = data_q;
  assign fill_lvl = cnt;
  assign tx_req   = (CMP_W'(cnt) <= CMP_W'(thresh));

endmodule

// File: rtl/sertx_queue_chk.sv
module sertx_queue_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             err_clr,
  input logic             err_en,
  input logic             wr_en,
  input logic             sh_busy,
  input logic             sh_load,
  input logic [CNT_W-1:0] fill_lvl,
  input logic             tx_req,
  input logic             tx_err,
  input logic             err_irq
);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= CNT_W'(DEPTH)); // R3

  AST_FILL_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (fill_lvl <= $past(fill_lvl) + CNT_W'(1))); // R8

  AST_FILL_FALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (fill_lvl + CNT_W'(1) >= $past(fill_lvl))); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_lvl == '0)); // R7

  AST_FLUSH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !sh_load); // R7

  AST_EMPTY_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl == '0) |-> tx_req); // R4

  AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |=> !sh_load); // R8

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> !sh_load); // R8

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> tx_err); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ($past(err_en) && $past(wr_en))); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !err_clr) |=> tx_err); // R10

endmodule

bind sertx_queue sertx_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .err_clr  (err_clr),
  .err_en   (err_en),
  .wr_en    (wr_en),
  .sh_busy  (sh_busy),
  .sh_load  (sh_load),
  .fill_lvl (fill_lvl),
  .tx_req   (tx_req),
  .tx_err   (tx_err),
  .err_irq  (err_irq)
);

// File: tb/sertx_queue_tb.sv
`timescale 1ns/1ps
module sertx_queue_tb;

  logic        clk, rst_n;
  logic        fifo_en, err_en, flush, err_clr, wr_en, sh_busy;
  logic [3:0]  len_cfg, thresh;
  logic [15:0] wr_data;
  logic        sh_load, tx_req, tx_err, err_irq;
  logic [15:0] sh_data;
  logic [3:0]  fill_lvl;

  int          total, bad;
  logic [15:0] exp_q [$];
  logic        stall, busy_before;
  int          busy_cnt;
  int          ship_len;

  sertx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .len_cfg(len_cfg),
    .thresh(thresh), .err_en(err_en), .flush(flush), .err_clr(err_clr),
    .wr_en(wr_en), .wr_data(wr_data), .sh_busy(sh_busy), .sh_load(sh_load),
    .sh_data(sh_data), .fill_lvl(fill_lvl), .tx_req(tx_req),
    .tx_err(tx_err), .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Shift engine model: busy for ship_len cycles after each load
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (sh_load) busy_cnt <= ship_len;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end
  assign sh_busy = stall || (busy_cnt != 0);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(input logic [15:0] d, input int len);
    int w;
    w = len + 1;
    if (w < 2) w = 2;
    return d & 16'((32'd1 << w) - 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  // Driver: one write, with the scoreboard told whether it overflows
  task automatic write_word(input logic [15:0] d, input bit ovf);
    wr_en   = 1'b1;
    wr_data = d;
    if (ovf) exp_q[exp_q.size()-1] = msk(d, int'(len_cfg));
    else     exp_q.push_back(msk(d, int'(len_cfg)));
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 400; i++) begin
      if (fill_lvl == 0 && !sh_busy && !sh_load) break;
      tick();
    end
    tick();
  endtask

  // Monitor: compares each load with the scoreboard head
  initial begin
    busy_before = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sh_load) begin
        chk(!busy_before, "R8", "load while busy", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected load", int'(sh_data), 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(sh_data == e, "R1 R2", "load data", int'(sh_data), int'(e));
        end
      end
      #6;
      busy_before = sh_busy;
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; stall = 1'b0; ship_len = 3;
    fifo_en = 1'b1; len_cfg = 4'd15; thresh = 4'd3; err_en = 1'b1;
    flush = 1'b0; err_clr = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #4;
    chk(fill_lvl == 0, "R11", "reset fill", int'(fill_lvl), 0);
    chk(tx_req == 1'b1, "R11", "reset tx_req", int'(tx_req), 1);
    chk(tx_err == 1'b0, "R11", "reset tx_err", int'(tx_err), 0);
    chk(err_irq == 1'b0, "R11", "reset err_irq", int'(err_irq), 0);
    chk(sh_load == 1'b0, "R11", "reset sh_load", int'(sh_load), 0);
    rst_n = 1'b1;
    tick();

    // R5: direct hand-off into idle shift register
    write_word(16'h1234, 1'b0);
    chk(sh_load == 1'b1, "R5", "bypass load", int'(sh_load), 1);
    chk(fill_lvl == 0, "R5", "bypass fill", int'(fill_lvl), 0);
    wait_drain();

    // R1/R3: fill to capacity while the shifter is held busy
    stall = 1'b1;
    for (int i = 0; i < 8; i++) write_word(16'hA000 + 16'(i), 1'b0);
    chk(fill_lvl == 8, "R3", "full level", int'(fill_lvl), 8);
    chk(tx_req == 1'b0, "R4", "req above thresh", int'(tx_req), 0);
    thresh = 4'd8;
    #1;
    chk(tx_req == 1'b1, "R4", "req thresh 8", int'(tx_req), 1);
    thresh = 4'd15;
    #1;
    chk(tx_req == 1'b1, "R4", "req thresh 15", int'(tx_req), 1);
    thresh = 4'd3;

    // R6: overflow overwrites newest, interrupt enabled
    write_word(16'hBEEF, 1'b1);
    chk(fill_lvl == 8, "R6", "ovf fill", int'(fill_lvl), 8);
    chk(tx_err == 1'b1, "R6", "ovf flag", int'(tx_err), 1);
    chk(err_irq == 1'b1, "R6", "ovf irq", int'(err_irq), 1);
    tick();
    chk(err_irq == 1'b0, "R6", "irq one cycle", int'(err_irq), 0);

    // Drain, checking the request tracks the level
    stall = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (fill_lvl == 0) break;
      chk(tx_req == (fill_lvl <= 4'd3), "R4", "req vs level", int'(tx_req),
          int'(fill_lvl <= 4'd3));
      tick();
    end
    wait_drain();
    chk(exp_q.size() == 0, "R1", "all delivered", exp_q.size(), 0);

    // R10: flag sticky, then cleared
    chk(tx_err == 1'b1, "R10", "sticky", int'(tx_err), 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(tx_err == 1'b0, "R10", "cleared", int'(tx_err), 0);

    // R2: width masking on both paths
    len_cfg = 4'd7;
    write_word(16'hABCD, 1'b0);
    chk(sh_data == 16'h00CD, "R2", "8-bit mask", int'(sh_data), 'hCD);
    wait_drain();
    len_cfg = 4'd0;
    write_word(16'hFFFF, 1'b0);
    chk(sh_data == 16'h0003, "R2", "2-bit mask", int'(sh_data), 3);
    wait_drain();
    len_cfg = 4'd4;
    stall = 1'b1;
    write_word(16'hFFFF, 1'b0);
    write_word(16'hFFE1, 1'b0);
    stall = 1'b0;
    wait_drain();
    len_cfg = 4'd15;

    // R7: flush with a simultaneous write
    stall = 1'b1;
    write_word(16'h1111, 1'b0);
    write_word(16'h2222, 1'b0);
    write_word(16'h3333, 1'b0);
    chk(fill_lvl == 3, "R3", "three held", int'(fill_lvl), 3);
    flush = 1'b1; wr_en = 1'b1; wr_data = 16'h7777;
    exp_q.delete();
    tick();
    flush = 1'b0; wr_en = 1'b0;
    chk(fill_lvl == 0, "R7", "flush level", int'(fill_lvl), 0);
    chk(sh_load == 1'b0, "R7", "flush no load", int'(sh_load), 0);
    stall = 1'b0;
    repeat (20) tick();
    chk(fill_lvl == 0, "R7", "write ignored", int'(fill_lvl), 0);

    // R9: disabled queue, one-word buffer, interrupt disabled
    fifo_en = 1'b0; err_en = 1'b0; stall = 1'b1;
    write_word(16'h0101, 1'b0);
    chk(fill_lvl == 1, "R9", "one held", int'(fill_lvl), 1);
    write_word(16'h0202, 1'b1);
    chk(fill_lvl == 1, "R9", "buffer ovf level", int'(fill_lvl), 1);
    chk(tx_err == 1'b1, "R9", "buffer ovf flag", int'(tx_err), 1);
    chk(err_irq == 1'b0, "R6", "irq masked", int'(err_irq), 0);
    err_clr = 1'b1;
    write_word(16'h0303, 1'b1);
    err_clr = 1'b0;
    chk(tx_err == 1'b1, "R10", "set beats clear", int'(tx_err), 1);
    stall = 1'b0;
    wait_drain();
    chk(exp_q.size() == 0, "R9", "buffer delivered", exp_q.size(), 0);

    finish_run();
  end

endmodule